// File: doc/BRIEF.md
# Capacitive I-V Sweep Sequencer

This controller runs a three-quadrant current-voltage trace of a photovoltaic device using two equal charge-transfer capacitors. Four switch enables are driven through a fixed order. First one capacitor is charged from the source. Next the device is connected in reverse bias and the first sweep runs until the current dies out near open circuit. The first capacitor is then discharged. The device is reconnected forward-biased from the second capacitor for the fourth-quadrant sweep. Finally the second capacitor is emptied. Each dwell in this order is set by a programmable cycle counter.

While a sweep runs, a pacing strobe asks for one voltage/current sample pair. Each segment has its own pacing interval: reverse voltage, forward voltage and the fourth quadrant. The controller moves from the reverse-voltage ADC channel to the forward-voltage channel when the voltage reaches zero. It ends each sweep when the offset-binary current code comes back near midscale. Sample pairs are stored in an internal buffer. When the trace is over they are streamed out as bytes over a valid/ready handshake toward a serial transmitter.

Top module: `ivsweep_seq`

## Requirements
- R1: After reset and between traces, `sw` is 0000, and `busy`, `done`, `tx_valid`, `sample_stb` and `adc_ch` are 0. Switch bits are: bit0 charges C1 from the source, bit1 connects the device, bit2 discharges C1, bit3 discharges C2. The switch outputs change only when the sequencer changes state.
- R2: A start in idle closes bit0 alone for exactly `chg_dwell`+1 cycles, then bit1 alone (sweep 1). Bits 0 and 1 are never high together.
- R3: Sweep 1 samples on channel 0 (`adc_ch`=0) until a sample with `v_code` <= `v_zero_thr` is taken. Every later sample of sweep 1 uses channel 1. Sweep 2 always uses channel 1.
- R4: A sample whose current code lies within `i_zero_thr` of 512 ends the current sweep; the test is |`i_code`-512| <= `i_zero_thr`. That sample is stored and no further sample is taken in that sweep. If the same sample also meets the crossing test, the sweep ends.
- R5: After sweep 1, `sw` is 0100 for exactly `c1_dis_dwell`+1 cycles, then 0110 (sweep 2).
- R6: After sweep 2, `sw` is 1000 for exactly `c2_dis_dwell`+1 cycles, then 0000.
- R7: Within a sweep, consecutive strobes are P+1 cycles apart. P is `pace_neg` when the next sample is on channel 0 of sweep 1, `pace_pos` when it is on channel 1 of sweep 1, and `pace_q4` in sweep 2.
- R8: Every strobe stores the pair {`v_code`,`i_code`} in sample order, up to DEPTH entries. Later strobes store nothing and set `overflow`. A new start clears the buffer and `overflow`.
- R9: Readout sends each stored pair, oldest first, as three bytes in this order: {4'b0,v[9:6]}, {v[5:0],i[9:8]}, i[7:0]. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R10: `done` rises in the cycle after the last byte is accepted, with `busy` low. `busy` is high from the start until then. `done` stays high until the next start, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a trace (idle only) |
| chg_dwell | input | CNT_W | C1 charge dwell, cycles minus one |
| c1_dis_dwell | input | CNT_W | C1 discharge dwell, cycles minus one |
| c2_dis_dwell | input | CNT_W | C2 discharge dwell, cycles minus one |
| pace_neg | input | CNT_W | Strobe interval minus one, reverse-voltage segment |
| pace_pos | input | CNT_W | Strobe interval minus one, forward-voltage segment |
| pace_q4 | input | CNT_W | Strobe interval minus one, fourth-quadrant sweep |
| v_zero_thr | input | 10 | Channel-0 voltage code treated as zero crossing |
| i_zero_thr | input | 10 | Current distance from midscale that ends a sweep |
| v_code | input | 10 | Voltage sample code |
| i_code | input | 10 | Current sample code, offset binary about 512 |
| sw | output | 4 | Switch enables |
| adc_ch | output | 1 | Voltage channel: 0 reverse, 1 forward |
| sample_stb | output | 1 | Samples are taken at the clock edge where this is high |
| busy | output | 1 | Trace in progress |
| done | output | 1 | Trace finished and fully read out |
| overflow | output | 1 | A sample was dropped because the buffer was full |
| tx_data | output | 8 | Readout byte |
| tx_valid | output | 1 | Readout byte valid |
| tx_ready | input | 1 | Transmitter accepts the byte |

## Verification
The zero-voltage crossing and the end-of-sweep current test can both be met by one sample of sweep 1. The bench provokes this with a stimulus row whose voltage is under the crossing threshold and whose current is exactly 512. It judges the result by three checks: the sweep stops after that sample, no further sweep-1 sample appears, and sweep 2 begins on channel 1. A second collision comes from a full buffer meeting an ongoing sweep. The bench checks that dropped samples still advance the sweep to its proper end and that `overflow` rises. Throughout, readout runs against a stalling `tx_ready`.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  parameter int unsigned SMP_W = 10;
  localparam int unsigned PAIR_W = 2 * SMP_W;
  localparam int unsigned PAD_W = 24;
  localparam logic [SMP_W-1:0] I_MID = SMP_W'(1) << (SMP_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHG, ST_SW1, ST_DIS1, ST_SW2, ST_DIS2, ST_DUMP
  } seq_st_t;

  // Current code near midscale (zero amps) within thr
  function automatic logic cur_at_rest(input logic [SMP_W-1:0] i,
                                       input logic [SMP_W-1:0] thr);
    logic [SMP_W-1:0] mag;
    mag = (i >= I_MID) ? (i - I_MID) : (I_MID - i);
    return mag <= thr;
  endfunction

  // Reverse-channel voltage code has reached zero
  function automatic logic volt_crossed(input logic [SMP_W-1:0] v,
                                        input logic [SMP_W-1:0] thr);
    return v <= thr;
  endfunction

  // Byte sel of a stored pair, most significant first
  function automatic logic [7:0] pair_byte(input logic [PAIR_W-1:0] p,
                                           input logic [1:0] sel);
    logic [PAD_W-1:0] w;
    w = PAD_W'(p);
    case (sel)
      2'd0:    return w[23:16];
      2'd1:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  // Switch pattern held in each state
  function automatic logic [3:0] sw_of(input seq_st_t s);
    case (s)
      ST_CHG:  return 4'b0001;
      ST_SW1:  return 4'b0010;
      ST_DIS1: return 4'b0100;
      ST_SW2:  return 4'b0110;
      ST_DIS2: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/ivs_pacer.sv
module ivs_pacer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic [CNT_W-1:0] reload_val,
  output logic             stb
);
  logic [CNT_W-1:0] cnt;

  assign stb = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (run) begin
      if (cnt == '0)       cnt <= reload_val;
      else                 cnt <= cnt - CNT_W'(1);
    end
  end

  // R7
  stb_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !load && run && $past(run) && $past(stb) && !$past(load)) |-> ($past(reload_val) == '0));
endmodule

// File: rtl/ivs_buffer.sv
module ivs_buffer import ivs_pkg::*; #(
  parameter int unsigned DEPTH = 500,
  localparam int unsigned AW = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAIR_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [PAIR_W-1:0] rd_data,
  output logic [AW-1:0]     count,
  output logic              ovf
);
  logic [PAIR_W-1:0] mem [DEPTH];
  logic full;

  assign full    = (count == AW'(DEPTH));
  assign rd_data = mem[rd_addr[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (wr && !full && !clr) mem[count[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (wr) begin
      if (full) ovf   <= 1'b1;
      else      count <= count + AW'(1);
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= AW'(DEPTH));
  // R8
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !clr) |=> ($stable(count) && ovf));
endmodule

// File: rtl/ivs_dumper.sv
module ivs_dumper import ivs_pkg::*; #(
  parameter int unsigned AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     count,
  output logic [AW-1:0]     rd_addr,
  input  logic [PAIR_W-1:0] rd_data,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              fin
);
  logic          active;
  logic [AW-1:0] idx;
  logic [1:0]    sel;
  logic          last_pair;

  assign last_pair = (idx == count - AW'(1));
  assign tx_valid  = active;
  assign tx_data   = pair_byte(rd_data, sel);
  assign rd_addr   = idx;
  assign fin       = active && tx_ready && (sel == 2'd2) && last_pair;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      sel    <= '0;
    end else if (go) begin
      active <= 1'b1;
      idx    <= '0;
      sel    <= '0;
    end else if (active && tx_ready) begin
      if (sel == 2'd2) begin
        sel <= '0;
        idx <= idx + AW'(1);
        if (last_pair) active <= 1'b0;
      end else begin
        sel <= sel + 2'd1;
      end
    end
  end

  // R9
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !go) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/ivsweep_seq.sv
module ivsweep_seq import ivs_pkg::*; #(
  parameter int unsigned DEPTH = 500,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] chg_dwell,
  input  logic [CNT_W-1:0] c1_dis_dwell,
  input  logic [CNT_W-1:0] c2_dis_dwell,
  input  logic [CNT_W-1:0] pace_neg,
  input  logic [CNT_W-1:0] pace_pos,
  input  logic [CNT_W-1:0] pace_q4,
  input  logic [SMP_W-1:0] v_zero_thr,
  input  logic [SMP_W-1:0] i_zero_thr,
  input  logic [SMP_W-1:0] v_code,
  input  logic [SMP_W-1:0] i_code,
  output logic [3:0]       sw,
  output logic             adc_ch,
  output logic             sample_stb,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  input  logic             tx_ready
);
  seq_st_t          state, nxt;
  logic [CNT_W-1:0] dcnt;
  logic             dwell_out;
  logic             stb, rest, end_now, cross_now;
  logic             pace_load, pace_run;
  logic [CNT_W-1:0] pace_load_val, pace_reload_val;
  logic [AW-1:0]    count, rd_addr;
  logic [PAIR_W-1:0] rd_data;
  logic             dump_go, dump_fin, trace_start;

  // Named events for the assertions and the pacer
  assign dwell_out   = (dcnt == '0);
  assign rest        = cur_at_rest(i_code, i_zero_thr);
  assign end_now     = stb && rest;
  assign cross_now   = stb && (state == ST_SW1) && !adc_ch && !rest &&
                       volt_crossed(v_code, v_zero_thr);
  assign trace_start = (state == ST_IDLE) && start;
  assign dump_go     = (state == ST_DIS2) && dwell_out && (count != '0);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start)     nxt = ST_CHG;
      ST_CHG:  if (dwell_out) nxt = ST_SW1;
      ST_SW1:  if (end_now)   nxt = ST_DIS1;
      ST_DIS1: if (dwell_out) nxt = ST_SW2;
      ST_SW2:  if (end_now)   nxt = ST_DIS2;
      ST_DIS2: if (dwell_out) nxt = (count == '0) ? ST_IDLE : ST_DUMP;
      ST_DUMP: if (dump_fin)  nxt = ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sw     <= 4'b0000;
      dcnt   <= '0;
      adc_ch <= 1'b0;
      done   <= 1'b0;
    end else begin
      state <= nxt;
      sw    <= sw_of(nxt);
      if (nxt != state) begin
        case (nxt)
          ST_CHG:  dcnt <= chg_dwell;
          ST_DIS1: dcnt <= c1_dis_dwell;
          ST_DIS2: dcnt <= c2_dis_dwell;
          default: dcnt <= dcnt;
        endcase
      end else if (!dwell_out) begin
        dcnt <= dcnt - CNT_W'(1);
      end
      if (trace_start)                          adc_ch <= 1'b0;
      else if (cross_now)                       adc_ch <= 1'b1;
      else if (nxt == ST_SW2 && state != ST_SW2) adc_ch <= 1'b1;
      else if (nxt == ST_IDLE)                  adc_ch <= 1'b0;
      if (trace_start) done <= 1'b0;
      else if ((state == ST_DUMP && dump_fin) ||
               (state == ST_DIS2 && dwell_out && count == '0)) done <= 1'b1;
    end
  end

  // Sample pacing
  assign pace_load       = dwell_out && (state == ST_CHG || state == ST_DIS1);
  assign pace_load_val   = (state == ST_CHG) ? pace_neg : pace_q4;
  assign pace_run        = (state == ST_SW1) || (state == ST_SW2);
  assign pace_reload_val = (state == ST_SW2) ? pace_q4 :
                           ((adc_ch || cross_now) ? pace_pos : pace_neg);

  ivs_pacer #(.CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(pace_load), .load_val(pace_load_val),
    .run(pace_run), .reload_val(pace_reload_val), .stb(stb)
  );

  ivs_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(trace_start), .wr(stb),
    .wr_data({v_code, i_code}), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .ovf(overflow)
  );

  ivs_dumper #(.AW(AW)) u_dump (
    .clk(clk), .rst_n(rst_n), .go(dump_go), .count(count),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .fin(dump_fin)
  );

  assign sample_stb = stb;
  assign busy       = (state != ST_IDLE);

  // R2
  s1_s2_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw[0] && sw[1]));
  // R1
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == $past(state)) |-> (sw == $past(sw)));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3
  ch_sweep2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SW2) |-> adc_ch);
  // R4
  end_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && rest && state == ST_SW1) |=> (sw == 4'b0100 && !sample_stb));
endmodule

// File: tb/sim_ivsweep_seq.sv
module sim_ivsweep_seq;
  localparam int DEPTH = 16;
  localparam int CNT_W = 16;
  localparam int CHG = 3, D1 = 5, D2 = 2, PNEG = 2, PPOS = 0, PQ4 = 1;
  localparam int NV = 16;
  // {v, i, expected channel}
  localparam logic [20:0] VEC [NV] = '{
    {10'd400, 10'd800, 1'b0}, {10'd300, 10'd790, 1'b0}, {10'd150, 10'd785, 1'b0},
    {10'd4,   10'd780, 1'b0}, {10'd40,  10'd770, 1'b1}, {10'd120, 10'd700, 1'b1},
    {10'd200, 10'd560, 1'b1}, {10'd230, 10'd515, 1'b1}, {10'd900, 10'd100, 1'b1},
    {10'd700, 10'd300, 1'b1}, {10'd500, 10'd450, 1'b1}, {10'd300, 10'd507, 1'b1},
    {10'd260, 10'd509, 1'b1},
    {10'd300, 10'd600, 1'b0}, {10'd2,   10'd512, 1'b0}, {10'd800, 10'd508, 1'b1}
  };

  logic clk = 0, rst_n = 0, start = 0, tx_ready = 0;
  logic [9:0] v_code = 0, i_code = 0;
  logic [3:0] sw;
  logic adc_ch, sample_stb, busy, done, overflow, tx_valid;
  logic [7:0] tx_data;

  ivsweep_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .chg_dwell(16'(CHG)), .c1_dis_dwell(16'(D1)), .c2_dis_dwell(16'(D2)),
    .pace_neg(16'(PNEG)), .pace_pos(16'(PPOS)), .pace_q4(16'(PQ4)),
    .v_zero_thr(10'd5), .i_zero_thr(10'd4), .v_code(v_code), .i_code(i_code),
    .sw(sw), .adc_ch(adc_ch), .sample_stb(sample_stb), .busy(busy), .done(done),
    .overflow(overflow), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  logic [9:0] sv [64];
  logic [9:0] si [64];
  logic       sch [64];
  int k = 0;
  bit stb_seen = 0;
  int last_stb = -1;
  logic [3:0] last_sw = 0, prev_sw = 0;
  int n_s1 = 0, n_s3 = 0, n_s4 = 0, n_bad = 0, nseq = 0;
  logic [3:0] seq [8];
  logic [7:0] got [256];
  int nb = 0, exp_nb = 0;
  bit prev_valid = 0, prev_ready = 0, chk_done_next = 0;
  logic [7:0] prev_data = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ADC model and port monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (stb_seen && k < 63) k++;
    v_code = sv[k];
    i_code = si[k];
    if (sample_stb) begin
      chk(adc_ch == sch[k], "R3 channel of sample", int'(adc_ch), int'(sch[k]));
      if (last_stb >= 0 && sw == last_sw)
        chk(cyc - last_stb == ((sw == 4'b0110) ? PQ4 : (adc_ch ? PPOS : PNEG)) + 1,
            "R7 strobe spacing", cyc - last_stb,
            ((sw == 4'b0110) ? PQ4 : (adc_ch ? PPOS : PNEG)) + 1);
      last_stb = cyc;
      last_sw = sw;
    end
    stb_seen = sample_stb;
    if (sw == 4'b0001) n_s1++;
    if (sw == 4'b0100) n_s3++;
    if (sw == 4'b1000) n_s4++;
    if (sw[0] && sw[1]) n_bad++;
    if (sw != prev_sw && nseq < 8) begin seq[nseq] = sw; nseq++; end
    prev_sw = sw;
    if (chk_done_next) begin
      chk(done && !busy, "R10 done after last byte", int'(done), 1);
      chk_done_next = 0;
    end
    if (prev_valid && !prev_ready)
      chk(tx_valid && tx_data == prev_data, "R9 hold while stalled", int'(tx_data), int'(prev_data));
    tx_ready = (cyc % 3) != 0;
    if (tx_valid && tx_ready) begin
      if (nb < 256) got[nb] = tx_data;
      nb++;
      if (nb == exp_nb) begin
        chk(!done, "R10 done low before last byte taken", int'(done), 0);
        chk_done_next = 1;
      end
    end
    prev_valid = tx_valid;
    prev_ready = tx_ready;
    prev_data = tx_data;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      wrap_up();
    end
  end

  task automatic load_rows(input int first, input int n);
    for (int r = 0; r < 64; r++) begin
      if (r < n) begin
        sv[r] = VEC[first + r][20:11];
        si[r] = VEC[first + r][10:1];
        sch[r] = VEC[first + r][0];
      end else begin
        sv[r] = 10'd100; si[r] = 10'd512; sch[r] = 1'b1;
      end
    end
  endtask

  task automatic run_trace(input int n_rows, input int n_store, input bit exp_ovf,
                           input bit poke_start);
    @(posedge clk);
    k = 0; stb_seen = 0; last_stb = -1; nb = 0; exp_nb = 3 * n_store;
    n_s1 = 0; n_s3 = 0; n_s4 = 0; n_bad = 0; nseq = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !done && !overflow, "R10 busy after start, done and overflow cleared (R8)",
        int'(busy), 1);
    if (poke_start) begin
      repeat (CHG + 3) @(negedge clk);
      chk(sw == 4'b0010, "R2 sweep 1 connection", int'(sw), 2);
      start = 1;
      @(negedge clk); start = 0;
      chk(sw == 4'b0010 && busy, "R10 start ignored while busy", int'(sw), 2);
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(k == n_rows, "R4 samples taken until zero current", k, n_rows);
    chk(nb == exp_nb, "R9 byte count", nb, exp_nb);
    for (int e = 0; e < n_store; e++) begin
      chk(got[3*e] == 8'(sv[e] >> 6), "R9 byte 0", int'(got[3*e]), int'(sv[e] >> 6));
      chk(got[3*e+1] == 8'({sv[e] % 64, 2'b00} | (si[e] >> 8)), "R9 byte 1",
          int'(got[3*e+1]), int'({sv[e] % 64, 2'b00} | (si[e] >> 8)));
      chk(got[3*e+2] == 8'(si[e] % 256), "R8 stored current order", int'(got[3*e+2]),
          int'(si[e] % 256));
    end
    chk(n_s1 == CHG + 1, "R2 charge dwell", n_s1, CHG + 1);
    chk(n_s3 == D1 + 1, "R5 C1 discharge dwell", n_s3, D1 + 1);
    chk(n_s4 == D2 + 1, "R6 C2 discharge dwell", n_s4, D2 + 1);
    chk(n_bad == 0, "R2 S1 and S2 together", n_bad, 0);
    chk(nseq == 6, "R5 switch step count", nseq, 6);
    chk(seq[0] == 4'b0001 && seq[1] == 4'b0010 && seq[2] == 4'b0100, "R5 first steps",
        int'(seq[2]), 4);
    chk(seq[3] == 4'b0110 && seq[4] == 4'b1000 && seq[5] == 4'b0000, "R6 last steps",
        int'(seq[5]), 0);
    chk(overflow == exp_ovf, "R8 overflow flag", int'(overflow), int'(exp_ovf));
    chk(done && !busy && sw == 4'b0000 && !tx_valid && !adc_ch, "R1 idle after trace",
        int'(sw), 0);
  endtask

  initial begin
    for (int r = 0; r < 64; r++) begin sv[r] = 0; si[r] = 10'd512; sch[r] = 0; end
    repeat (3) @(negedge clk);
    chk(sw == 4'b0000 && !busy && !done && !tx_valid && !adc_ch && !sample_stb,
        "R1 reset state", int'(sw), 0);
    rst_n = 1;
    @(negedge clk);
    chk(sw == 4'b0000 && !busy && !done, "R1 idle after reset release", int'(busy), 0);
    // Main table: both sweeps, crossing at row 3, current boundary 5 vs 4
    load_rows(0, 13);
    run_trace(13, 13, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(done, "R10 done held until next start", int'(done), 1);
    // Crossing and zero current on the same sample
    load_rows(13, 3);
    run_trace(3, 3, 1'b0, 1'b0);
    // Buffer overflow: 21 sweep-1 samples plus one sweep-2 sample
    @(posedge clk);
    for (int r = 0; r < 64; r++) begin
      sv[r] = 10'd100 + 10'(r); si[r] = 10'd800; sch[r] = 1'b0;
    end
    si[20] = 10'd512;
    sv[21] = 10'd900; si[21] = 10'd512; sch[21] = 1'b1;
    run_trace(22, DEPTH, 1'b1, 1'b0);
    // New start clears overflow
    load_rows(13, 3);
    run_trace(3, 3, 1'b0, 1'b0);
    wrap_up();
  end
endmodule